// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Controller

This block runs a three-wire serial EEPROM on its own. It drives chip select, serial clock and serial data-in, and it samples the part's serial data-out. A host starts one operation at a time with a one-cycle strobe. The operations are read, write, erase, write-enable and write-disable. The host supplies a word address and, for writes, a 16-bit data word. The controller reports `busy` while it works. When a host command finishes it gives a one-cycle `done`, and at that point the read word and the error flag are valid.

Parts come with either 6 or 8 address bits. The controller does not need to be told which. Straight after reset it runs a probe read to the all-ones address with 8 address bits and looks at one bit of the captured serial stream. The answer sets the address width for every later command and is shown on `addr_wide`. A write or an erase starts internal programming in the part. For these the controller raises chip select again after the frame and waits for data-out to go high. If data-out stays low for longer than a fixed number of half clock periods, the command ends with the error flag set.

The state machine has seven states. BOOT loads the probe frame. IDLE waits for a strobe. LOW drives the next data bit with the clock low. HIGH raises the clock and samples data-out. END holds chip select low for one half-period. POLL waits for data-out. DONE gives the result.

The transitions are:
- BOOT→LOW always.
- IDLE→LOW on an accepted strobe.
- LOW→HIGH after one half-period.
- HIGH→LOW after one half-period while bits remain.
- HIGH→END after one half-period on the last bit.
- END→POLL after one half-period for a write or an erase.
- END→DONE after one half-period for every other frame.
- POLL→DONE when data-out is high or the poll limit is reached.
- DONE→IDLE always.

Top module: `sprom_ctrl`

## Requirements
- R1: After reset, `busy` is high and the controller sends a probe frame of 29 clock pulses on its own. The data-in bits of that frame are 0,0,1,1,0, then eight 1s, then sixteen 0s. The probe never pulses `done`.
- R2: `addr_wide` takes the value of data-out as sampled in the 11th clock of the probe frame, which is bit 18 of the 29-bit capture counted from the last bit. A 1 selects 8 address bits and a 0 selects 6. The value is held until the next reset.
- R3: Every host frame starts with one 0 bit, then the start bit 1, then two opcode bits, then the address MSB first. The opcode is 10 for read, 01 for write, 11 for erase and 00 for write-enable and write-disable. `cmd_op` is coded 0 read, 1 write, 2 erase, 3 write-enable, 4 write-disable.
- R4: Data-in changes only while the clock is low. Each clock high phase lasts exactly HALF_CYC cycles, and the clock is high only while chip select is high.
- R5: A read frame sends sixteen 1 bits after the address. `rdata` takes the last 16 data-out samples, MSB first.
- R6: A write frame sends the 16 `cmd_wdata` bits MSB first after the address. Chip select then goes low for one half-period and rises again for the completion poll.
- R7: An erase frame ends after the address and is followed by the same completion poll as a write.
- R8: Write-enable sends the address field 11110000 with 8-bit addressing or 111100 with 6-bit addressing, and then no poll.
- R9: Write-disable sends an all-zero address field.
- R10: If data-out does not go high within POLL_LIMIT half-periods of polling, `err` is high when `done` pulses. The next accepted command clears it.
- R11: `done` is a one-cycle pulse with chip select low. `busy` is low from the following cycle.
- R12: A strobe is ignored while `busy` is high. A strobe with `cmd_op` of 5 to 7 is ignored at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous release |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_op | input | 3 | Operation code (see R3) |
| cmd_addr | input | 8 | Word address; low 6 bits used with narrow parts |
| cmd_wdata | input | 16 | Data word for write |
| busy | output | 1 | Controller occupied |
| done | output | 1 | Host command finished |
| err | output | 1 | Completion poll timed out |
| rdata | output | 16 | Word from the last read |
| addr_wide | output | 1 | 1 when 8 address bits are in use |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data to the EEPROM |
| ee_do | input | 1 | Serial data from the EEPROM |

## Verification
A wrong bit counter or shift pointer shows up on the data-in pin within the same frame. The frame is one bit too long or too short, or its fields are misaligned, and the bench compares each captured frame bit by bit. A wrong width decision during the probe shows up at the first host command after reset, both on `addr_wide` and in the address field length. A poll counter or state that never leaves POLL shows up as `err` at the wrong time or as a `done` that never arrives, within a few hundred cycles.

// File: rtl/sprom_pkg.sv
package sprom_pkg;
    typedef enum logic [2:0] {
        OP_READ  = 3'd0,
        OP_WRITE = 3'd1,
        OP_ERASE = 3'd2,
        OP_WREN  = 3'd3,
        OP_WRDIS = 3'd4
    } op_e;

    typedef enum logic [2:0] {
        S_BOOT, S_IDLE, S_LOW, S_HIGH, S_END, S_POLL, S_DONE
    } st_e;
endpackage

// File: rtl/sprom_tick.sv
module sprom_tick #(
    parameter int HALF_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = $clog2(HALF_CYC + 1);
    logic [CW-1:0] cnt;

    assign tick = run && (cnt == CW'(HALF_CYC - 1));

    always_ff @(posedge clk) begin
        if (!rst_n)             cnt <= '0;
        else if (!run || tick)  cnt <= '0;
        else                    cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/sprom_frame.sv
module sprom_frame
    import sprom_pkg::*;
#(
    parameter int AW_MAX  = 8,
    parameter int AW_MIN  = 6,
    parameter int DW      = 16,
    parameter int FRAME_W = 5 + AW_MAX + DW,
    parameter int NB_W    = $clog2(FRAME_W + 1)
) (
    input  logic               probe,
    input  logic               wide,
    input  op_e                op,
    input  logic [AW_MAX-1:0]  addr,
    input  logic [DW-1:0]      wdata,
    output logic [FRAME_W-1:0] frame,
    output logic [NB_W-1:0]    nbits
);
    localparam int PAD_W = FRAME_W - 4 - AW_MAX - DW;
    localparam int PAD_N = FRAME_W - 4 - AW_MIN - DW;

    logic [2:0]        cmd;
    logic [AW_MAX-1:0] a;
    logic [DW-1:0]     d;
    logic              has_data;

    always_comb begin
        unique case (op)
            OP_READ:  begin cmd = 3'b110; a = addr;  d = '1;    has_data = 1'b1; end
            OP_WRITE: begin cmd = 3'b101; a = addr;  d = wdata; has_data = 1'b1; end
            OP_ERASE: begin cmd = 3'b111; a = addr;  d = '0;    has_data = 1'b0; end
            OP_WREN:  begin
                cmd = 3'b100;
                a   = wide ? ~({AW_MAX{1'b1}} >> 4)
                           : AW_MAX'(~({AW_MIN{1'b1}} >> 4));
                d   = '0; has_data = 1'b0;
            end
            default:  begin cmd = 3'b100; a = '0;    d = '0;    has_data = 1'b0; end
        endcase
    end

    always_comb begin
        if (probe) begin
            frame = {2'b00, 3'b110, {AW_MAX{1'b1}}, {DW{1'b0}}};
            nbits = NB_W'(FRAME_W);
        end else if (wide) begin
            frame = {1'b0, cmd, a, d, {PAD_W{1'b0}}};
            nbits = has_data ? NB_W'(4 + AW_MAX + DW) : NB_W'(4 + AW_MAX);
        end else begin
            frame = {1'b0, cmd, a[AW_MIN-1:0], d, {PAD_N{1'b0}}};
            nbits = has_data ? NB_W'(4 + AW_MIN + DW) : NB_W'(4 + AW_MIN);
        end
    end
endmodule

// File: rtl/sprom_ctrl.sv
module sprom_ctrl
    import sprom_pkg::*;
#(
    parameter int HALF_CYC   = 4,
    parameter int POLL_LIMIT = 64,
    parameter int AW_MAX     = 8,
    parameter int AW_MIN     = 6,
    parameter int DW         = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [AW_MAX-1:0] cmd_addr,
    input  logic [DW-1:0]     cmd_wdata,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [DW-1:0]     rdata,
    output logic              addr_wide,
    output logic              ee_cs,
    output logic              ee_sk,
    output logic              ee_di,
    input  logic              ee_do
);
    localparam int FRAME_W   = 5 + AW_MAX + DW;
    localparam int NB_W      = $clog2(FRAME_W + 1);
    localparam int PC_W      = $clog2(POLL_LIMIT + 1);
    localparam int PROBE_BIT = AW_MAX + DW - AW_MIN;

    st_e               st, st_nx;
    op_e               op_q;
    logic              probe_q, wide_q, err_q, tick, run, accept;
    logic [FRAME_W-1:0] sh_q, cap_q, frame;
    logic [NB_W-1:0]   nb, left_q;
    logic [PC_W-1:0]   pc_q;
    logic [DW-1:0]     rd_q;

    assign accept = (st == S_IDLE) && cmd_valid && (cmd_op <= 3'd4);
    assign run    = (st == S_LOW) || (st == S_HIGH) || (st == S_END) || (st == S_POLL);

    sprom_tick #(.HALF_CYC(HALF_CYC)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
    );

    sprom_frame #(.AW_MAX(AW_MAX), .AW_MIN(AW_MIN), .DW(DW), .FRAME_W(FRAME_W), .NB_W(NB_W)) u_frame (
        .probe(st == S_BOOT), .wide(wide_q), .op(op_e'(cmd_op)),
        .addr(cmd_addr), .wdata(cmd_wdata), .frame(frame), .nbits(nb)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_BOOT;
        else        st <= st_nx;
    end

    // Next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            S_BOOT: st_nx = S_LOW;
            S_IDLE: if (accept) st_nx = S_LOW;
            S_LOW:  if (tick) st_nx = S_HIGH;
            S_HIGH: if (tick) st_nx = (left_q == NB_W'(1)) ? S_END : S_LOW;
            S_END:  if (tick) st_nx = (!probe_q && (op_q == OP_WRITE || op_q == OP_ERASE))
                                      ? S_POLL : S_DONE;
            S_POLL: if (tick && (ee_do || pc_q == PC_W'(POLL_LIMIT - 1))) st_nx = S_DONE;
            S_DONE: st_nx = S_IDLE;
            default: st_nx = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        ee_cs = (st == S_LOW) || (st == S_HIGH) || (st == S_POLL);
        ee_sk = (st == S_HIGH);
        ee_di = ((st == S_LOW) || (st == S_HIGH)) && sh_q[FRAME_W-1];
        busy  = (st != S_IDLE);
        done  = (st == S_DONE) && !probe_q;
    end

    // Datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= OP_READ;
            probe_q <= 1'b1;
            wide_q  <= 1'b1;
            err_q   <= 1'b0;
            sh_q    <= '0;
            cap_q   <= '0;
            left_q  <= '0;
            pc_q    <= '0;
            rd_q    <= '0;
        end else begin
            if (st == S_BOOT || accept) begin
                sh_q    <= frame;
                left_q  <= nb;
                cap_q   <= '0;
                pc_q    <= '0;
                probe_q <= (st == S_BOOT);
            end
            if (accept) begin
                op_q  <= op_e'(cmd_op);
                err_q <= 1'b0;
            end
            if (st == S_HIGH && tick) begin
                sh_q   <= sh_q << 1;
                cap_q  <= {cap_q[FRAME_W-2:0], ee_do};
                left_q <= left_q - 1'b1;
            end
            if (st == S_POLL && tick) begin
                pc_q <= pc_q + 1'b1;
                if (!ee_do && pc_q == PC_W'(POLL_LIMIT - 1)) err_q <= 1'b1;
            end
            if (st == S_DONE) begin
                if (probe_q)               wide_q <= cap_q[PROBE_BIT];
                else if (op_q == OP_READ)  rd_q   <= cap_q[DW-1:0];
            end
        end
    end

    assign err       = err_q;
    assign rdata     = rd_q;
    assign addr_wide = wide_q;
endmodule

// File: rtl/sprom_ctrl_chk.sv
module sprom_ctrl_chk #(
    parameter int HALF_CYC = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [2:0] cmd_op,
    input logic       busy,
    input logic       done,
    input logic       err,
    input logic       ee_cs,
    input logic       ee_sk,
    input logic       ee_di
);
    logic        sk_d;
    logic [15:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sk_d   <= 1'b0;
            hi_cnt <= '0;
        end else begin
            sk_d <= ee_sk;
            if (ee_sk && !sk_d) hi_cnt <= 16'd1;
            else if (ee_sk)     hi_cnt <= hi_cnt + 16'd1;
        end
    end

    // R4
    sk_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ee_sk |-> ee_cs);

    // R4
    di_stable_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_sk && $past(ee_sk)) |-> $stable(ee_di));

    // R4
    sk_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ee_sk) |-> (hi_cnt == 16'(HALF_CYC)));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    done_cs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !ee_cs);

    // R10
    err_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> done);

    // R12
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && cmd_op <= 3'd4) |=> busy);
endmodule

bind sprom_ctrl sprom_ctrl_chk #(.HALF_CYC(HALF_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .busy(busy), .done(done), .err(err), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di)
);

// File: tb/sprom_ctrl_tb.sv
module sprom_ctrl_tb;
    localparam int HALF = 4;
    localparam int PROG = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic [7:0]  cmd_addr = 8'd0;
    logic [15:0] cmd_wdata = 16'd0;
    logic        busy, done, err, addr_wide, ee_cs, ee_sk, ee_di, ee_do;
    logic [15:0] rdata;

    always #5 clk = ~clk;

    sprom_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .busy(busy), .done(done),
        .err(err), .rdata(rdata), .addr_wide(addr_wide), .ee_cs(ee_cs),
        .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
    );

    int checks = 0;
    int failures = 0;

    // EEPROM model and pin monitor
    logic [15:0] mem [256];
    logic [1:0]  m_op;
    logic [7:0]  m_adr;
    logic [15:0] m_sh, m_dat;
    int          m_ph, m_cnt, m_busy;
    bit          m_wen, m_init;
    bit          m_aw8 = 1'b1;
    bit          m_stuck = 1'b0;
    logic        do_r;
    logic [31:0] fr_bits, last_bits;
    int          fr_n, last_n, cs_rises, done_cnt, sk_hi, sk_bad, di_bad;
    logic        cs_d, sk_d, di_d;

    function automatic logic [15:0] memfn(input int i);
        return 16'(i * 515) ^ 16'hA55A;
    endfunction

    assign ee_do = !ee_cs ? 1'b1 : ((m_busy != 0 || m_stuck) ? 1'b0 : do_r);

    always @(negedge clk) begin
        if (!m_init) begin
            for (int i = 0; i < 256; i++) mem[i] = memfn(i);
            m_init = 1'b1; m_wen = 1'b0; m_busy = 0; do_r = 1'b1; m_ph = 0; m_cnt = 0;
            fr_n = 0; last_n = 0; cs_rises = 0; done_cnt = 0; sk_hi = 0; sk_bad = 0; di_bad = 0;
            cs_d = 1'b0; sk_d = 1'b0; di_d = 1'b0; fr_bits = '0; last_bits = '0;
            m_op = '0; m_adr = '0; m_sh = '0; m_dat = '0;
        end
        if (m_busy > 0) m_busy--;
        if (ee_cs && !cs_d) begin
            fr_n = 0; fr_bits = '0; m_ph = 0; m_cnt = 0; do_r = 1'b1; cs_rises++;
        end
        if (ee_cs && ee_sk && !sk_d) begin
            fr_bits = {fr_bits[30:0], ee_di}; fr_n++;
            case (m_ph)
                0: if (ee_di) begin m_ph = 1; m_cnt = 0; m_op = 2'b00; end
                1: begin
                    m_op = {m_op[0], ee_di}; m_cnt++;
                    if (m_cnt == 2) begin m_ph = 2; m_cnt = 0; m_adr = '0; end
                end
                2: begin
                    m_adr = {m_adr[6:0], ee_di}; m_cnt++;
                    if (m_cnt == (m_aw8 ? 8 : 6)) begin
                        m_cnt = 0;
                        if (m_op == 2'b10) begin m_ph = 3; do_r = 1'b0; m_sh = mem[m_adr]; end
                        else if (m_op == 2'b01) m_ph = 4;
                        else m_ph = 5;
                    end
                end
                3: begin do_r = m_sh[15]; m_sh = {m_sh[14:0], 1'b0}; end
                4: begin
                    m_dat = {m_dat[14:0], ee_di}; m_cnt++;
                    if (m_cnt == 16) m_ph = 5;
                end
                default: ;
            endcase
        end
        if (!ee_cs && cs_d) begin
            if (fr_n != 0) begin last_bits = fr_bits; last_n = fr_n; end
            if (m_ph == 5) begin
                if (m_op == 2'b01 && m_wen) begin mem[m_adr] = m_dat; m_busy = PROG; end
                else if (m_op == 2'b11 && m_wen) begin mem[m_adr] = 16'hFFFF; m_busy = PROG; end
                else if (m_op == 2'b00) begin
                    if ((m_aw8 ? m_adr[7:6] : m_adr[5:4]) == 2'b11) m_wen = 1'b1;
                    else if ((m_aw8 ? m_adr[7:6] : m_adr[5:4]) == 2'b00) m_wen = 1'b0;
                end
            end
            m_ph = 0; do_r = 1'b1;
        end
        if (ee_sk) sk_hi++;
        if (!ee_sk && sk_d) begin
            if (sk_hi != HALF) sk_bad++;
            sk_hi = 0;
        end
        if (ee_sk && sk_d && ee_di != di_d) di_bad++;
        if (done) done_cnt++;
        cs_d = ee_cs; sk_d = ee_sk; di_d = ee_di;
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic chk_frame(input string req, input int n, input logic [31:0] exp);
        logic [31:0] mask;
        mask = (n >= 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
        check(last_n == n, {req, " frame length"}, longint'(last_n), longint'(n));
        check((last_bits & mask) == exp, {req, " frame bits"}, longint'(last_bits & mask), longint'(exp));
    endtask

    task automatic issue(input logic [2:0] op, input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        cmd_op = op; cmd_addr = a; cmd_wdata = d; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
        check(ee_cs == 1'b0, "R11 cs low at done", longint'(ee_cs), 0);
        @(negedge clk);
        check(done == 1'b0 && busy == 1'b0, "R11 done single pulse, idle after",
              longint'({done, busy}), 0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_probe(input bit wide_exp);
        int d0;
        d0 = done_cnt;
        do_reset();
        check(busy == 1'b1, "R1 busy after reset", longint'(busy), 1);
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
        check(done_cnt == d0, "R1 probe gives no done", longint'(done_cnt), longint'(d0));
        chk_frame("R1", 29, {3'b000, 2'b00, 3'b110, 8'hFF, 16'h0000});
        check(addr_wide == wide_exp, "R2 width detect", longint'(addr_wide), longint'(wide_exp));
    endtask

    task automatic t_read(input logic [7:0] a);
        issue(3'd0, a, 16'h0);
        wait_done();
        check(rdata == memfn(int'(a)), "R5 read data", longint'(rdata), longint'(memfn(int'(a))));
        chk_frame("R3 R5 read", 28, {4'b0, 1'b0, 3'b110, a, 16'hFFFF});
    endtask

    task automatic t_program();
        int c0;
        c0 = cs_rises;
        issue(3'd3, 8'h00, 16'h0);
        wait_done();
        chk_frame("R8 wren wide", 12, {20'b0, 1'b0, 3'b100, 8'hF0});
        check(cs_rises == c0 + 1, "R8 no poll", longint'(cs_rises), longint'(c0 + 1));
        c0 = cs_rises;
        issue(3'd1, 8'h12, 16'hBEEF);
        wait_done();
        chk_frame("R6 write", 28, {4'b0, 1'b0, 3'b101, 8'h12, 16'hBEEF});
        check(cs_rises == c0 + 2, "R6 poll after write", longint'(cs_rises), longint'(c0 + 2));
        check(err == 1'b0, "R6 no error", longint'(err), 0);
        issue(3'd0, 8'h12, 16'h0);
        wait_done();
        check(rdata == 16'hBEEF, "R6 readback", longint'(rdata), 64'hBEEF);
        c0 = cs_rises;
        issue(3'd2, 8'h12, 16'h0);
        wait_done();
        chk_frame("R7 erase", 12, {20'b0, 1'b0, 3'b111, 8'h12});
        check(cs_rises == c0 + 2, "R7 poll after erase", longint'(cs_rises), longint'(c0 + 2));
        issue(3'd0, 8'h12, 16'h0);
        wait_done();
        check(rdata == 16'hFFFF, "R7 erased readback", longint'(rdata), 64'hFFFF);
        issue(3'd4, 8'h55, 16'h0);
        wait_done();
        chk_frame("R9 wrdis", 12, {20'b0, 1'b0, 3'b100, 8'h00});
    endtask

    task automatic t_ignore();
        int d0;
        d0 = done_cnt;
        issue(3'd0, 8'h40, 16'h0);
        repeat (20) @(negedge clk);
        issue(3'd1, 8'h41, 16'h1111);
        wait_done();
        repeat (300) @(negedge clk);
        check(done_cnt == d0 + 1, "R12 strobe while busy ignored", longint'(done_cnt), longint'(d0 + 1));
        check(rdata == memfn(32'h40), "R12 read intact", longint'(rdata), longint'(memfn(32'h40)));
        issue(3'd5, 8'h00, 16'h0);
        check(busy == 1'b0, "R12 bad op ignored", longint'(busy), 0);
        repeat (5) @(negedge clk);
        check(busy == 1'b0 && done_cnt == d0 + 1, "R12 bad op no activity",
              longint'(busy), 0);
    endtask

    task automatic t_timeout();
        issue(3'd3, 8'h00, 16'h0);
        wait_done();
        m_stuck = 1'b1;
        issue(3'd1, 8'h30, 16'h1234);
        while (!done) @(negedge clk);
        check(err == 1'b1, "R10 timeout error", longint'(err), 1);
        check(ee_cs == 1'b0, "R11 cs low after timeout", longint'(ee_cs), 0);
        m_stuck = 1'b0;
        repeat (60) @(negedge clk);
        issue(3'd0, 8'h30, 16'h0);
        wait_done();
        check(err == 1'b0, "R10 error cleared", longint'(err), 0);
    endtask

    task automatic t_narrow();
        m_aw8 = 1'b0;
        t_probe(1'b0);
        issue(3'd0, 8'h05, 16'h0);
        wait_done();
        check(rdata == memfn(5), "R5 narrow read", longint'(rdata), longint'(memfn(5)));
        chk_frame("R3 narrow read", 26, {6'b0, 1'b0, 3'b110, 6'h05, 16'hFFFF});
        issue(3'd3, 8'h00, 16'h0);
        wait_done();
        chk_frame("R8 wren narrow", 10, {22'b0, 1'b0, 3'b100, 6'h3C});
    endtask

    initial begin
        t_probe(1'b1);
        t_read(8'h12);
        t_read(8'hA7);
        t_program();
        t_ignore();
        t_timeout();
        t_narrow();
        check(sk_bad == 0, "R4 clock high width", longint'(sk_bad), 0);
        check(di_bad == 0, "R4 data stable while clock high", longint'(di_bad), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures + 1);
        $finish;
    end
endmodule